// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block takes fire strobes from three event-timer channels and turns each into a one-cycle pulse on one line of a 16-line interrupt bus. Each channel carries an enable bit and a 5-bit route field. A global enable gates every channel. A fire event is the rising edge of a channel's strobe. The pulse leaves one clock after that edge.

When the legacy-mode input is high, the route fields of channels 0 and 1 are overridden. Channel 0 then always lands on line 0 and channel 1 on line 8, while channel 2 keeps its own route. In the same mode the block cuts off two older interrupt sources. The interval-timer request is forced low. The real-time-clock periodic request is frozen, so it can neither rise nor fall until legacy mode is left.

Top module: `legacy_irq_router`

## Requirements
- R1: A fire event is a rising edge of `fire[c]` sampled while `ch_en[c]` and `glb_en` are both high. It produces exactly one pulse, one clock cycle wide, on the target line of `irq_out`. The pulse appears in the cycle after the edge. A strobe held high gives only one pulse.
- R2: Outside legacy mode, the target line of channel c is the value of `ch_route[c*5 +: 5]`.
- R3: While `legacy_mode` is high, channel 0 always targets line 0 and channel 1 always targets line 8, whatever their route fields hold.
- R4: Channel 2 targets its route field in both modes.
- R5: No pulse is produced for a channel when `ch_en[c]` or `glb_en` is low in the cycle of its rising edge.
- R6: When two or more channels hit the same line in the same cycle, that line carries one pulse and no other line is raised.
- R7: A route value of 16 or more targets no line, and the event raises nothing.
- R8: `pit_irq_out` follows `pit_irq_in` one cycle later while legacy mode is low. It is held low in the cycle after any cycle in which `legacy_mode` is high.
- R9: `rtc_irq_out` follows `rtc_irq_in` one cycle later while legacy mode is low. It keeps its value unchanged, with no rise and no fall, while `legacy_mode` is high.
- R10: After reset, `irq_out`, `pit_irq_out` and `rtc_irq_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire | input | 3 | Per-channel fire strobe; the rising edge is the event |
| ch_en | input | 3 | Per-channel interrupt enable |
| ch_route | input | 15 | Route fields; channel c uses bits c*5+4 down to c*5 |
| glb_en | input | 1 | Global enable |
| legacy_mode | input | 1 | Legacy replacement mode |
| pit_irq_in | input | 1 | Interval-timer interrupt request |
| rtc_irq_in | input | 1 | Real-time-clock periodic interrupt request |
| irq_out | output | 16 | Interrupt lines, one-cycle pulses |
| pit_irq_out | output | 1 | Gated interval-timer request |
| rtc_irq_out | output | 1 | Gated real-time-clock request |

## Verification
Each channel is fired alone through several route values, both inside and outside legacy mode. This separates the route-field path from the fixed legacy lines and confirms that channel 2 is never overridden. Further patterns cover:
- a strobe held high for several cycles, which separates edge detection from level following;
- channels that collide on one line, and channels that stay on separate lines;
- route values past the last line;
- each enable cleared on its own.

The two older sources are toggled on both sides of legacy-mode entry and exit, so that freezing is told apart from forcing low.

// File: rtl/legacy_irq_router.sv
module legacy_irq_router #(
  parameter int NCH    = 3,
  parameter int NLINES = 16,
  parameter int RW     = 5,
  parameter int LEG_A  = 0,
  parameter int LEG_B  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      fire,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH*RW-1:0]   ch_route,
  input  logic                glb_en,
  input  logic                legacy_mode,
  input  logic                pit_irq_in,
  input  logic                rtc_irq_in,
  output logic [NLINES-1:0]   irq_out,
  output logic                pit_irq_out,
  output logic                rtc_irq_out
);

  localparam logic [RW:0] LIM = (RW+1)'(NLINES);

  logic [NCH-1:0]             fire_q;
  logic [NCH-1:0]             evt;
  logic [NCH-1:0][NLINES-1:0] hit;
  logic [NLINES-1:0]          irq_d;

  assign evt = fire & ~fire_q & ch_en & {NCH{glb_en}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RW-1:0] tgt;
    if (c == 0) begin : g_a
      assign tgt = legacy_mode ? RW'(LEG_A) : ch_route[c*RW +: RW];
    end else if (c == 1) begin : g_b
      assign tgt = legacy_mode ? RW'(LEG_B) : ch_route[c*RW +: RW];
    end else begin : g_n
      assign tgt = ch_route[c*RW +: RW];
    end
    assign hit[c] = (evt[c] && ({1'b0, tgt} < LIM)) ? (NLINES'(1) << tgt) : '0;
  end

  always_comb begin
    irq_d = '0;
    for (int c = 0; c < NCH; c++) irq_d = irq_d | hit[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q      <= '0;
      irq_out     <= '0;
      pit_irq_out <= 1'b0;
      rtc_irq_out <= 1'b0;
    end else begin
      fire_q      <= fire;
      irq_out     <= irq_d;
      pit_irq_out <= pit_irq_in & ~legacy_mode;
      if (!legacy_mode) rtc_irq_out <= rtc_irq_in;
    end
  end

  a_r2_route_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fire[2]) && ch_en[2] && glb_en && !ch_route[2*RW+RW-1])
    |=> irq_out[$past(ch_route[2*RW +: 4])]);

  a_r3_legacy_a: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_mode && $rose(fire[0]) && ch_en[0] && glb_en) |=> irq_out[LEG_A]);

  a_r3_legacy_b: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_mode && $rose(fire[1]) && ch_en[1] && glb_en) |=> irq_out[LEG_B]);

  a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en) |=> (irq_out == '0));

  a_r8_pit_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_mode && pit_irq_in) |=> pit_irq_out);

  a_r9_rtc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode |=> $stable(rtc_irq_out));

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= NCH);

endmodule

// File: tb/legacy_irq_router_test.sv
module legacy_irq_router_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  fire = 0, ch_en = 0;
  logic [14:0] ch_route = 0;
  logic        glb_en = 0, legacy_mode = 0, pit_irq_in = 0, rtc_irq_in = 0;
  logic [15:0] irq_out;
  logic        pit_irq_out, rtc_irq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  legacy_irq_router uut (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ch_en(ch_en), .ch_route(ch_route),
    .glb_en(glb_en), .legacy_mode(legacy_mode), .pit_irq_in(pit_irq_in),
    .rtc_irq_in(rtc_irq_in), .irq_out(irq_out), .pit_irq_out(pit_irq_out),
    .rtc_irq_out(rtc_irq_out));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] line(int r);
    return (r < 16) ? (16'(1) << r) : 16'h0;
  endfunction

  task automatic shot(logic [2:0] m, logic [15:0] exp, string req);
    fire = m;
    @(negedge clk) chk(req, irq_out, exp);
    fire = 0;
    @(negedge clk) chk({req, " pulse ends"}, irq_out, 16'h0);
  endtask

  task automatic set_routes(int a, int b, int c);
    ch_route = {5'(c), 5'(b), 5'(a)};
  endtask

  task automatic t_reset;
    chk("R10 irq", irq_out, 16'h0);
    chk("R10 pit", {15'h0, pit_irq_out}, 16'h0);
    chk("R10 rtc", {15'h0, rtc_irq_out}, 16'h0);
  endtask

  task automatic t_route;
    glb_en = 1; ch_en = 3'b111; legacy_mode = 0;
    set_routes(5, 15, 3);
    shot(3'b001, line(5), "R2 ch0");
    shot(3'b010, line(15), "R2 ch1");
    shot(3'b100, line(3), "R2 ch2");
    set_routes(0, 1, 12);
    shot(3'b111, line(0) | line(1) | line(12), "R2 all three");
  endtask

  task automatic t_legacy;
    legacy_mode = 1;
    set_routes(5, 15, 3);
    shot(3'b001, line(0), "R3 ch0 fixed");
    shot(3'b010, line(8), "R3 ch1 fixed");
    shot(3'b100, line(3), "R4 ch2 keeps route");
    legacy_mode = 0;
    shot(3'b001, line(5), "R2 after legacy exit");
  endtask

  task automatic t_hold;
    set_routes(7, 9, 11);
    fire = 3'b010;
    @(negedge clk) chk("R1 first", irq_out, line(9));
    @(negedge clk) chk("R1 held no repeat", irq_out, 16'h0);
    @(negedge clk) chk("R1 held no repeat 2", irq_out, 16'h0);
    fire = 0;
    @(negedge clk);
  endtask

  task automatic t_enable;
    set_routes(4, 6, 10);
    ch_en = 3'b110;
    shot(3'b001, 16'h0, "R5 channel off");
    shot(3'b011, line(6), "R5 other channel on");
    ch_en = 3'b111; glb_en = 0;
    shot(3'b111, 16'h0, "R5 global off");
    glb_en = 1;
  endtask

  task automatic t_collide;
    set_routes(6, 6, 6);
    shot(3'b111, line(6), "R6 three on one line");
    legacy_mode = 1;
    set_routes(3, 3, 8);
    shot(3'b110, line(8), "R6 legacy ch1 and ch2");
    legacy_mode = 0;
  endtask

  task automatic t_range;
    set_routes(16, 31, 20);
    shot(3'b111, 16'h0, "R7 out of range");
    set_routes(16, 2, 31);
    shot(3'b111, line(2), "R7 only valid one");
  endtask

  task automatic t_pit;
    pit_irq_in = 1;
    @(negedge clk) chk("R8 pass high", {15'h0, pit_irq_out}, 16'h1);
    legacy_mode = 1;
    @(negedge clk) chk("R8 blocked", {15'h0, pit_irq_out}, 16'h0);
    legacy_mode = 0;
    @(negedge clk) chk("R8 restored", {15'h0, pit_irq_out}, 16'h1);
    pit_irq_in = 0;
    @(negedge clk) chk("R8 pass low", {15'h0, pit_irq_out}, 16'h0);
  endtask

  task automatic t_rtc;
    rtc_irq_in = 1;
    @(negedge clk) chk("R9 follow high", {15'h0, rtc_irq_out}, 16'h1);
    legacy_mode = 1; rtc_irq_in = 0;
    @(negedge clk) chk("R9 no lower", {15'h0, rtc_irq_out}, 16'h1);
    @(negedge clk) chk("R9 no lower 2", {15'h0, rtc_irq_out}, 16'h1);
    legacy_mode = 0;
    @(negedge clk) chk("R9 follow low", {15'h0, rtc_irq_out}, 16'h0);
    legacy_mode = 1; rtc_irq_in = 1;
    @(negedge clk) chk("R9 no raise", {15'h0, rtc_irq_out}, 16'h0);
    legacy_mode = 0;
    @(negedge clk) chk("R9 follow after exit", {15'h0, rtc_irq_out}, 16'h1);
    rtc_irq_in = 0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_route;
    t_legacy;
    t_hold;
    t_enable;
    t_collide;
    t_range;
    t_pit;
    t_rtc;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
    end
  end
endmodule